// File: doc/BRIEF.md
# Entropy Cell Bias Trim Servo

This block is the digital half of a self-balancing true random bit source. A cross-coupled entropy cell resolves to a raw bit on each sample strobe. The servo takes that bit and retunes the cell's physical trims so that the next decision leans toward the opposite value. Over time the raw stream settles to an even share of ones and zeros, even when one die's cell is skewed differently from another's.

Two 8-bit thermometer codes enable extra threshold taps on one inverter or the other. Both are derived from a single signed balance counter, so only one side is ever trimmed above mid-scale. Two 4-bit codes set load compensation on the two coupling lines. These line codes move only when four equal bits arrive in a row. The raw bit is forwarded with one cycle of latency. A sticky flag reports a loop that has been pinned at an end stop for too long. A low `cal_en` freezes the trims while bits keep flowing.

Top module: `trim_servo`

## Requirements
- R1: After reset, `stat_balance` is 0, both inverter trims are 8'h0F, both line trims are 4'b1000, and `cal_limit` and `out_vld` are 0.
- R2: An accepted bit (`raw_vld`=1 at a clock edge) appears on `out_bit` with `out_vld`=1 in the following cycle. `out_vld` is 0 after an edge with no accepted bit.
- R3: With `cal_en`=1, an accepted 0 raises the balance by 1 and an accepted 1 lowers it by 1. Positive balance favours ones.
- R4: If an accepted bit equals the previously accepted bit, the balance moves by one extra step in the same direction (total ±2).
- R5: The number of ones in `trim_inv_a`, filled from bit 0 upward, is 4 + ceil(max(balance,0)/4). `trim_inv_b` uses max(-balance,0) the same way. Both never exceed half at once.
- R6: When an accepted bit and the three accepted bits before it are all equal (with `cal_en`=1), the line trims step by one. A run of zeros gives `trim_line_a`+1 and `trim_line_b`-1, and a run of ones gives the reverse. Alternating bits never move them.
- R7: The balance saturates at -16 and +16, and the line trims saturate at 0 and 15, with no wraparound.
- R8: While `cal_en`=0, the balance and line trims do not change, but bits are still forwarded and the bit history still advances.
- R9: `cal_limit` becomes 1 after the 16th consecutive accepted bit that arrives while the balance is at ±16 or a line trim is at 0 or 15. It then stays 1 until reset.
- R10: Cycles without `raw_vld` change no trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Trim update enable |
| raw_vld | input | 1 | Raw bit strobe |
| raw_bit | input | 1 | Raw bit from the entropy cell |
| out_vld | output | 1 | Forwarded bit valid |
| out_bit | output | 1 | Forwarded raw bit |
| trim_inv_a | output | 8 | Threshold tap thermometer, inverter A |
| trim_inv_b | output | 8 | Threshold tap thermometer, inverter B |
| trim_line_a | output | 4 | Load compensation, coupling line A |
| trim_line_b | output | 4 | Load compensation, coupling line B |
| cal_limit | output | 1 | Sticky end-stop alarm |
| stat_balance | output | 6 | Signed balance counter (status) |

## Verification
One accepted bit can close a run of two and a run of four at once. The balance then takes its double step in the same cycle that both line trims move. The bench provokes this by resuming calibration after a frozen stretch of equal bits, and checks the exact balance and line values one cycle later. A second overlap is saturation together with end-stop counting: a long run of ones drives the balance and a line trim into their stops, and the bench checks that the alarm rises on the sixteenth pinned bit while the trims stay clamped.

// File: rtl/trim_servo_pkg.sv
package trim_servo_pkg;

   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

endpackage

// File: rtl/servo_balance.sv
module servo_balance
   import trim_servo_pkg::*;
#(
   parameter int BAL_MAX = 16,
   parameter int BAL_W   = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step_en,
   input  logic                    bit_i,
   input  logic                    run2,
   output logic signed [BAL_W-1:0] bal_o
);

   logic signed [BAL_W-1:0] bal_q;
   int                      delta;
   int                      nxt;

   always_comb begin
      delta = bit_i ? -1 : 1;
      if (run2) delta = delta * 2;
      nxt = clamp_int(int'(bal_q) + delta, -BAL_MAX, BAL_MAX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bal_q <= '0;
      else if (step_en) bal_q <= BAL_W'(nxt);
   end

   assign bal_o = bal_q;

   // R7: balance never leaves its range
   p_bal_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bal_q) <= BAL_MAX) && (int'(bal_q) >= -BAL_MAX));

   // R8 / R10: no step, no change
   p_bal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(bal_q));

   // R3: a zero below the top stop raises the balance
   p_bal_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !bit_i && (int'(bal_q) < BAL_MAX)) |=> (bal_q > $past(bal_q)));

endmodule

// File: rtl/servo_line.sv
module servo_line
   import trim_servo_pkg::*;
#(
   parameter int LINE_W     = 4,
   parameter bit UP_ON_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              bit_i,
   output logic [LINE_W-1:0] trim_o
);

   localparam int LMAX = (1 << LINE_W) - 1;
   localparam int LMID = 1 << (LINE_W - 1);

   logic [LINE_W-1:0] trim_q;
   int                nxt;

   always_comb begin
      if ((bit_i == 1'b0) == UP_ON_ZERO) nxt = clamp_int(int'(trim_q) + 1, 0, LMAX);
      else                                nxt = clamp_int(int'(trim_q) - 1, 0, LMAX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       trim_q <= LINE_W'(LMID);
      else if (step_en) trim_q <= LINE_W'(nxt);
   end

   assign trim_o = trim_q;

   // R6 / R8: no run of four, no movement
   p_line_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(trim_q));

   // R7: a step at an end stop leaves the trim there
   p_line_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && (trim_q == LINE_W'(LMAX)) && ((bit_i == 1'b0) == UP_ON_ZERO))
      |=> (trim_q == LINE_W'(LMAX)));

endmodule

// File: rtl/servo_thermo.sv
module servo_thermo #(
   parameter int TRIM_W = 8,
   parameter int MW     = 5,
   parameter int DIV    = 4
) (
   input  logic [MW-1:0]     mag,
   output logic [TRIM_W-1:0] code
);

   localparam int HALF = TRIM_W / 2;

   int ones;

   always_comb ones = HALF + (int'(mag) + DIV - 1) / DIV;

   for (genvar i = 0; i < TRIM_W; i++) begin : g_tap
      assign code[i] = (ones > i);
   end

endmodule

// File: rtl/servo_limit.sv
module servo_limit #(
   parameter int LIMIT_RUN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic acc,
   input  logic at_stop,
   output logic flag_o
);

   localparam int CW = $clog2(LIMIT_RUN + 1);

   logic [CW-1:0] cnt_q;
   logic          flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (acc) begin
         if (at_stop) begin
            if (cnt_q != CW'(LIMIT_RUN)) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(LIMIT_RUN - 1)) flag_q <= 1'b1;
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign flag_o = flag_q;

   // R9: the alarm is sticky
   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q |=> flag_q);

   // R9: the alarm only rises on an accepted pinned bit
   p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !(acc && at_stop)) |=> !flag_q);

endmodule

// File: rtl/trim_servo.sv
module trim_servo #(
   parameter int TRIM_W    = 8,
   parameter int LINE_W    = 4,
   parameter int BAL_MAX   = 16,
   parameter int RUN_LONG  = 4,
   parameter int LIMIT_RUN = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cal_en,
   input  logic                                raw_vld,
   input  logic                                raw_bit,
   output logic                                out_vld,
   output logic                                out_bit,
   output logic [TRIM_W-1:0]                   trim_inv_a,
   output logic [TRIM_W-1:0]                   trim_inv_b,
   output logic [LINE_W-1:0]                   trim_line_a,
   output logic [LINE_W-1:0]                   trim_line_b,
   output logic                                cal_limit,
   output logic signed [$clog2(BAL_MAX)+1:0]   stat_balance
);

   localparam int BAL_W = $clog2(BAL_MAX) + 2;
   localparam int HALF  = TRIM_W / 2;
   localparam int DIV   = BAL_MAX / HALF;
   localparam int HIST  = RUN_LONG - 1;
   localparam int HN_W  = $clog2(HIST + 1);
   localparam int LMAX  = (1 << LINE_W) - 1;

   if (TRIM_W % 2 != 0 || TRIM_W < 2) begin : g_bad_trim
      $error("TRIM_W must be even and at least 2");
   end
   if (BAL_MAX % HALF != 0) begin : g_bad_bal
      $error("BAL_MAX must be a multiple of TRIM_W/2");
   end
   if (RUN_LONG < 3 || LINE_W < 2) begin : g_bad_run
      $error("RUN_LONG must be at least 3 and LINE_W at least 2");
   end

   // bit history, newest in bit 0
   logic [HIST-1:0] hist_q;
   logic [HN_W-1:0] hist_n_q;
   logic            run2, run_long;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q   <= '0;
         hist_n_q <= '0;
         out_vld  <= 1'b0;
         out_bit  <= 1'b0;
      end else begin
         out_vld <= raw_vld;
         if (raw_vld) begin
            out_bit <= raw_bit;
            hist_q  <= {hist_q[HIST-2:0], raw_bit};
            if (hist_n_q != HN_W'(HIST)) hist_n_q <= hist_n_q + 1'b1;
         end
      end
   end

   assign run2     = (hist_n_q != '0) && (hist_q[0] == raw_bit);
   assign run_long = (hist_n_q == HN_W'(HIST)) && (hist_q == {HIST{raw_bit}});

   // balance counter
   logic signed [BAL_W-1:0] bal;
   logic                    step_en;

   assign step_en = raw_vld && cal_en;

   servo_balance #(.BAL_MAX(BAL_MAX), .BAL_W(BAL_W)) u_bal (
      .clk(clk), .rst_n(rst_n), .step_en(step_en),
      .bit_i(raw_bit), .run2(run2), .bal_o(bal)
   );

   // thermometer taps, one side at a time
   logic [BAL_W-1:0] neg_bal;
   logic [BAL_W-2:0] mag [2];
   logic [TRIM_W-1:0] inv_code [2];

   assign neg_bal = -bal;
   assign mag[0]  = (bal > 0) ? bal[BAL_W-2:0]     : '0;
   assign mag[1]  = (bal < 0) ? neg_bal[BAL_W-2:0] : '0;

   for (genvar s = 0; s < 2; s++) begin : g_inv
      servo_thermo #(.TRIM_W(TRIM_W), .MW(BAL_W-1), .DIV(DIV)) u_th (
         .mag(mag[s]), .code(inv_code[s])
      );
   end

   // coupling line trims, mirrored directions
   logic [LINE_W-1:0] line [2];

   for (genvar s = 0; s < 2; s++) begin : g_line
      servo_line #(.LINE_W(LINE_W), .UP_ON_ZERO(s == 0)) u_ln (
         .clk(clk), .rst_n(rst_n), .step_en(step_en && run_long),
         .bit_i(raw_bit), .trim_o(line[s])
      );
   end

   // end-stop alarm
   logic at_stop;

   assign at_stop = (int'(bal) == BAL_MAX) || (int'(bal) == -BAL_MAX) ||
                    (line[0] == '0) || (line[0] == LINE_W'(LMAX)) ||
                    (line[1] == '0) || (line[1] == LINE_W'(LMAX));

   servo_limit #(.LIMIT_RUN(LIMIT_RUN)) u_lim (
      .clk(clk), .rst_n(rst_n), .acc(raw_vld), .at_stop(at_stop), .flag_o(cal_limit)
   );

   assign trim_inv_a   = inv_code[0];
   assign trim_inv_b   = inv_code[1];
   assign trim_line_a  = line[0];
   assign trim_line_b  = line[1];
   assign stat_balance = bal;

   // R2: forwarding with one cycle of latency
   p_fwd_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      raw_vld |=> (out_vld && (out_bit == $past(raw_bit))));

   p_fwd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_vld |=> !out_vld);

   // R5: only one inverter trimmed above mid-scale
   p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(($countones(trim_inv_a) > HALF) && ($countones(trim_inv_b) > HALF)));

   // R6: line trims move in opposite directions
   p_line_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && run_long && !raw_bit && (line[0] != LINE_W'(LMAX)) && (line[1] != '0))
      |=> ((trim_line_a == $past(trim_line_a) + 1'b1) &&
           (trim_line_b == $past(trim_line_b) - 1'b1)));

endmodule

// File: tb/tb_trim_servo.sv
module tb_trim_servo;

   localparam int CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cal_en = 1'b0;
   logic              raw_vld = 1'b0;
   logic              raw_bit = 1'b0;
   logic              out_vld, out_bit, cal_limit;
   logic [7:0]        trim_inv_a, trim_inv_b;
   logic [3:0]        trim_line_a, trim_line_b;
   logic signed [5:0] stat_balance;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trim_servo dut (
      .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .raw_vld(raw_vld), .raw_bit(raw_bit),
      .out_vld(out_vld), .out_bit(out_bit), .trim_inv_a(trim_inv_a), .trim_inv_b(trim_inv_b),
      .trim_line_a(trim_line_a), .trim_line_b(trim_line_b), .cal_limit(cal_limit),
      .stat_balance(stat_balance)
   );

   // behavioural reference
   int  m_bal, m_la, m_lb, m_cnt;
   bit  m_flag, m_ob, m_ov;
   int  hist[$];

   always @(posedge clk) begin : model
      int d;
      bit stop, r2, r4;
      if (!rst_n) begin
         m_bal = 0; m_la = 8; m_lb = 8; m_cnt = 0;
         m_flag = 0; m_ob = 0; m_ov = 0;
         hist.delete();
      end else if (raw_vld) begin
         stop = (m_bal == 16) || (m_bal == -16) || (m_la == 0) || (m_la == 15) ||
                (m_lb == 0) || (m_lb == 15);
         if (stop) begin
            m_cnt++;
            if (m_cnt >= 16) m_flag = 1;
         end else m_cnt = 0;
         r2 = (hist.size() >= 1) && (hist[hist.size()-1] == raw_bit);
         r4 = (hist.size() == 3) && (hist[0] == raw_bit) && (hist[1] == raw_bit) &&
              (hist[2] == raw_bit);
         if (cal_en) begin
            d = raw_bit ? -1 : 1;
            if (r2) d = d * 2;
            m_bal = m_bal + d;
            if (m_bal > 16) m_bal = 16;
            if (m_bal < -16) m_bal = -16;
            if (r4) begin
               if (!raw_bit) begin
                  if (m_la < 15) m_la++;
                  if (m_lb > 0) m_lb--;
               end else begin
                  if (m_la > 0) m_la--;
                  if (m_lb < 15) m_lb++;
               end
            end
         end
         hist.push_back(int'(raw_bit));
         if (hist.size() > 3) void'(hist.pop_front());
         m_ob = raw_bit;
         m_ov = 1;
      end else begin
         m_ov = 0;
      end
   end

   function automatic int therm(input int bal_side);
      int ones;
      ones = 4 + ((bal_side > 0) ? (bal_side + 3) / 4 : 0);
      return (1 << ones) - 1;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2", "out_vld", int'(out_vld), int'(m_ov));
      if (m_ov) chk("R2", "out_bit", int'(out_bit), int'(m_ob));
      chk("R3", "balance", int'(stat_balance), m_bal);
      chk("R5", "trim_inv_a", int'(trim_inv_a), therm(m_bal));
      chk("R5", "trim_inv_b", int'(trim_inv_b), therm(-m_bal));
      chk("R6", "trim_line_a", int'(trim_line_a), m_la);
      chk("R6", "trim_line_b", int'(trim_line_b), m_lb);
      chk("R9", "cal_limit", int'(cal_limit), int'(m_flag));
   endtask

   task automatic send(input bit v, input bit b, input bit e);
      raw_vld = v;
      raw_bit = b;
      cal_en  = e;
      @(negedge clk);
      compare_all();
   endtask

   int unsigned seed = 32'h1234_5678;

   function automatic int rnd100();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 16) % 100);
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      int keep_a, keep_b, keep_bal, p1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", "balance", int'(stat_balance), 0);
      chk("R1", "trim_inv_a", int'(trim_inv_a), 8'h0F);
      chk("R1", "trim_inv_b", int'(trim_inv_b), 8'h0F);
      chk("R1", "trim_line_a", int'(trim_line_a), 8);
      chk("R1", "trim_line_b", int'(trim_line_b), 8);
      chk("R1", "cal_limit", int'(cal_limit), 0);
      chk("R1", "out_vld", int'(out_vld), 0);

      // R3 single step, R4 double step, R5 mapping
      send(1, 0, 1);
      chk("R3", "first zero step", int'(stat_balance), 1);
      chk("R5", "one extra tap on A", int'(trim_inv_a), 8'h1F);
      send(1, 0, 1);
      chk("R4", "repeat zero double step", int'(stat_balance), 3);
      send(1, 1, 1);
      chk("R3", "single one step", int'(stat_balance), 2);
      send(0, 1, 1);
      chk("R10", "idle cycle balance", int'(stat_balance), 2);
      chk("R2", "idle cycle out_vld", int'(out_vld), 0);

      // biased cell model
      for (int i = 0; i < 500; i++) begin
         p1 = 70 - 3 * m_bal;
         if (p1 < 5) p1 = 5;
         if (p1 > 95) p1 = 95;
         send(rnd100() < 85, rnd100() < p1, 1);
      end

      // R6: alternating bits leave line trims alone
      send(1, 0, 1); send(1, 1, 1); send(1, 0, 1);
      keep_a = int'(trim_line_a);
      keep_b = int'(trim_line_b);
      for (int i = 0; i < 10; i++) send(1, (i % 2) == 0, 1);
      chk("R6", "alternating line_a", int'(trim_line_a), keep_a);
      chk("R6", "alternating line_b", int'(trim_line_b), keep_b);

      // R7 saturation and R9 alarm on a long run of ones
      for (int i = 0; i < 40; i++) send(1, 1, 1);
      chk("R7", "balance low stop", int'(stat_balance), -16);
      chk("R7", "line_a low stop", int'(trim_line_a), 0);
      chk("R7", "line_b high stop", int'(trim_line_b), 15);
      chk("R5", "inverter B full", int'(trim_inv_b), 8'hFF);
      chk("R9", "alarm raised", int'(cal_limit), 1);

      // R8: frozen trims while zeros keep flowing
      keep_bal = int'(stat_balance);
      for (int i = 0; i < 10; i++) send(1, 0, 0);
      chk("R8", "frozen balance", int'(stat_balance), keep_bal);
      chk("R8", "frozen line_a", int'(trim_line_a), 0);
      chk("R8", "forward while frozen", int'(out_bit), 0);
      for (int i = 0; i < 5; i++) send(0, 1, 1);
      chk("R10", "idle line_b", int'(trim_line_b), 15);

      // R4 and R6 in the same cycle
      send(1, 0, 1);
      chk("R4", "double step with run", int'(stat_balance), -14);
      chk("R6", "line_a step on zero run", int'(trim_line_a), 1);
      chk("R6", "line_b step on zero run", int'(trim_line_b), 14);
      chk("R9", "alarm sticky", int'(cal_limit), 1);

      for (int i = 0; i < 300; i++) begin
         p1 = 30 - 3 * m_bal;
         if (p1 < 5) p1 = 5;
         if (p1 > 95) p1 = 95;
         send(rnd100() < 70, rnd100() < p1, rnd100() < 90);
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule